// File: doc/BRIEF.md
# Normalizing Barrel Shifter

This block is the shift stage of a 16-bit fixed-point datapath. Each accepted operation takes a 16-bit operand, a signed 8-bit shift count and an operation code. It returns a registered 32-bit result and a registered 5-bit exponent one clock later. The operations are:

- logical and arithmetic shifts in either direction;
- normalization, which moves the first significant bit up beside the sign bit;
- denormalization, which shifts back right by a supplied exponent;
- exponent derivation, which reports the number of redundant sign bits and leaves the result unchanged.

Values wider than 16 bits are processed in pieces. A half-select places the operand in the upper or the lower half of the 32-bit word before the shift. A merge mode ORs the new shifted word into the previous result, so two passes build one double-word result. For block floating-point groups, a block exponent register keeps the smallest exponent derived since reset. Only derive operations marked as block members update it.

Top module: `norm_shifter`

## Requirements
- R1: While rst_ni is low, and after its release until the first accepted operation, result_o is 0, exp_o is 0, blk_exp_o is 15 and valid_o is 0.
- R2: The derived exponent of an operand is the number of bits below bit 15, counted downward from bit 14, that equal bit 15 before the first bit that differs. It saturates at 15 when all 16 bits are equal. exp_o takes this value one cycle after an accepted operation with op_i = 2 or op_i = 4.
- R3: Before the shift, the operand is placed in a 32-bit word. With hi_sel_i = 1 it goes in bits 31:16 and bits 15:0 are zero. With hi_sel_i = 0 it goes in bits 15:0, and bits 31:16 are copies of data_i[15] for op_i = 1 or 3 and zero for op_i = 0 or 2.
- R4: op_i = 0 is a logical shift. A positive count_i shifts left, a negative count_i shifts right, and vacated bits are filled with zeros.
- R5: op_i = 1 is an arithmetic shift. It behaves as R4, except that right shifts fill vacated bits with bit 31 of the placed word.
- R6: A shift magnitude of 32 or more gives an all-fill word: all zeros for left shifts and logical right shifts, and all copies of placed bit 31 for arithmetic right shifts. This includes count_i = -128.
- R7: op_i = 2 normalizes. It shifts the placed word left by the operand's derived exponent (R2), whatever count_i is.
- R8: op_i = 3 denormalizes. It shifts the placed word arithmetically right by count_i; a negative count_i shifts left by its magnitude.
- R9: For op_i 0 to 3, when or_mode_i = 1 the new result_o is the shifted word ORed with the previous result_o. When or_mode_i = 0 it is the shifted word alone.
- R10: op_i = 4 derives the exponent and leaves result_o unchanged. If blk_i = 1, blk_exp_o becomes the smaller of its current value and the derived exponent. No other operation changes blk_exp_o.
- R11: An operation with valid_i = 0 or op_i of 5, 6 or 7 is ignored. result_o, exp_o and blk_exp_o hold, and no valid_o pulse is produced.
- R12: valid_o is high for exactly one cycle, one cycle after each accepted operation, and back-to-back operations give back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation request |
| op_i | input | 3 | Operation code (0 lsh, 1 ash, 2 norm, 3 denorm, 4 exp) |
| data_i | input | 16 | Operand |
| count_i | input | 8 | Signed shift count / denormalize exponent |
| hi_sel_i | input | 1 | Place operand in the upper half |
| or_mode_i | input | 1 | OR the new word into the previous result |
| blk_i | input | 1 | Derive operation belongs to a block group |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Shifted result |
| exp_o | output | 5 | Derived exponent |
| blk_exp_o | output | 5 | Smallest block exponent since reset |

## Verification
The bench targets the following corner cases, listed with the wrong behaviour each one exposes:

- **Saturation boundary.** Counts of exactly 32, -40 and -128 are driven. A shifter that wraps the magnitude to five bits would return a partly shifted word instead of the fill pattern.
- **Exponent extremes.** All-zero, all-ones, 0x0001 and 0x4000 operands are driven. An exponent detector that counts from the wrong bit, or that does not saturate at 15, reports an exponent off by one or 16.
- **Lower-half fill.** Lower-half placement is checked for both arithmetic and logical shifts. A design that sign-extends in the wrong modes shows stray ones in the upper half.
- **Merge and block exponent.** A two-pass double-word right shift with OR merge is driven. Derive operations with and without the block flag are mixed, including a larger exponent after a smaller one. These catch a lost merge, an unconditional block update and a block exponent that can grow.
- **Ignored operations.** Reserved codes and idle cycles are driven. A design that does not ignore them would change the held result or emit a spurious valid pulse.

// File: rtl/norm_shifter_pkg.sv
package norm_shifter_pkg;
  typedef enum logic [2:0] {
    OP_LSH    = 3'd0,
    OP_ASH    = 3'd1,
    OP_NORM   = 3'd2,
    OP_DENORM = 3'd3,
    OP_EXP    = 3'd4
  } shop_e;

  function automatic logic op_legal(logic [2:0] op);
    return op <= 3'd4;
  endfunction
endpackage

// File: rtl/ns_exp_detect.sv
module ns_exp_detect #(
  parameter int DATA_W = 16,
  localparam int EXP_W = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [EXP_W-1:0]  exp_o
);
  always_comb begin
    logic run;
    int   n;
    run = 1'b1;
    n   = 0;
    for (int i = DATA_W - 2; i >= 0; i--) begin
      if (run && (data_i[i] == data_i[DATA_W-1])) n++;
      else run = 1'b0;
    end
    exp_o = EXP_W'(n);
  end
endmodule

// File: rtl/ns_shift_array.sv
module ns_shift_array #(
  parameter int DATA_W = 16,
  parameter int AMT_W  = 9,
  localparam int RES_W = 2 * DATA_W,
  localparam int SH_W  = $clog2(RES_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              hi_sel_i,
  input  logic              arith_i,
  input  logic [AMT_W-1:0]  amt_i,     // two's complement, >= 0 shifts left
  output logic [RES_W-1:0]  word_o
);
  logic [RES_W-1:0] placed;
  logic [AMT_W-1:0] mag;
  logic [SH_W-1:0]  sh;
  logic             left, big, fill;

  always_comb begin
    if (hi_sel_i) placed = {data_i, {DATA_W{1'b0}}};
    else          placed = {{DATA_W{arith_i & data_i[DATA_W-1]}}, data_i};
  end

  assign left = ~amt_i[AMT_W-1];
  assign mag  = left ? amt_i : (~amt_i + 1'b1);
  assign big  = mag >= AMT_W'(RES_W);
  assign sh   = mag[SH_W-1:0];
  assign fill = arith_i & placed[RES_W-1];

  always_comb begin
    if (left) begin
      word_o = big ? '0 : (placed << sh);
    end else if (big) begin
      word_o = {RES_W{fill}};
    end else if (arith_i) begin
      word_o = RES_W'($signed(placed) >>> sh);
    end else begin
      word_o = placed >> sh;
    end
  end
endmodule

// File: rtl/ns_blk_exp.sv
module ns_blk_exp #(
  parameter int EXP_W   = 5,
  parameter int EXP_MAX = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic [EXP_W-1:0] blk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     blk_o <= EXP_W'(EXP_MAX);
    else if (upd_i && exp_i < blk_o) blk_o <= exp_i;
  end
endmodule

// File: rtl/norm_shifter.sv
module norm_shifter
  import norm_shifter_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  localparam int RES_W   = 2 * DATA_W,
  localparam int EXP_W   = $clog2(DATA_W) + 1,
  localparam int AMT_W   = CNT_W + 1,
  localparam int EXP_MAX = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              hi_sel_i,
  input  logic              or_mode_i,
  input  logic              blk_i,
  output logic              valid_o,
  output logic [RES_W-1:0]  result_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [EXP_W-1:0]  blk_exp_o
);
  shop_e            op;
  logic             acc, arith;
  logic [EXP_W-1:0] exp_d;
  logic [AMT_W-1:0] cnt_x, amt;
  logic [RES_W-1:0] word;

  assign op    = shop_e'(op_i);
  assign acc   = valid_i & op_legal(op_i);
  assign arith = (op == OP_ASH) || (op == OP_DENORM);
  assign cnt_x = {count_i[CNT_W-1], count_i};

  always_comb begin
    case (op)
      OP_NORM:   amt = AMT_W'(exp_d);
      OP_DENORM: amt = '0 - cnt_x;   // right by the supplied exponent
      default:   amt = cnt_x;
    endcase
  end

  ns_exp_detect #(.DATA_W(DATA_W)) u_exp (
    .data_i (data_i),
    .exp_o  (exp_d)
  );

  ns_shift_array #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_sh (
    .data_i   (data_i),
    .hi_sel_i (hi_sel_i),
    .arith_i  (arith),
    .amt_i    (amt),
    .word_o   (word)
  );

  ns_blk_exp #(.EXP_W(EXP_W), .EXP_MAX(EXP_MAX)) u_blk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (acc && op == OP_EXP && blk_i),
    .exp_i  (exp_d),
    .blk_o  (blk_exp_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      exp_o    <= '0;
    end else begin
      valid_o <= acc;
      if (acc) begin
        if (op != OP_EXP) result_o <= or_mode_i ? (result_o | word) : word;
        if (op == OP_EXP || op == OP_NORM) exp_o <= exp_d;
      end
    end
  end
endmodule

// File: rtl/norm_shifter_chk.sv
module norm_shifter_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  localparam int RES_W = 2 * DATA_W,
  localparam int EXP_W = $clog2(DATA_W) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] data_i,
  input logic [CNT_W-1:0]  count_i,
  input logic              hi_sel_i,
  input logic              or_mode_i,
  input logic              blk_i,
  input logic              valid_o,
  input logic [RES_W-1:0]  result_o,
  input logic [EXP_W-1:0]  exp_o,
  input logic [EXP_W-1:0]  blk_exp_o
);
  a_r12_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i && op_i <= 3'd4));

  a_r2_exp_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_o <= EXP_W'(DATA_W - 1));

  a_r10_blk_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_exp_o <= $past(blk_exp_o));

  a_r10_exp_keeps_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd4) |=> $stable(result_o));

  a_r11_ignored_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && op_i <= 3'd4) |=> ($stable(result_o) && $stable(exp_o) && $stable(blk_exp_o)));

  a_r7_norm_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd2 && hi_sel_i && !or_mode_i)
      |=> ((result_o[RES_W-1] != result_o[RES_W-2]) || result_o == '0));
endmodule

bind norm_shifter norm_shifter_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_norm_shifter.sv
`timescale 1ns/100ps
module sim_norm_shifter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [15:0] data_i = '0;
  logic [7:0]  count_i = '0;
  logic        hi_sel_i = 1'b0, or_mode_i = 1'b0, blk_i = 1'b0;
  logic        valid_o;
  logic [31:0] result_o;
  logic [4:0]  exp_o, blk_exp_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic [4:0]  e;
    logic [4:0]  blk;
    string       tag;
  } item_t;
  item_t sb[$];

  logic [31:0] m_res = '0;
  logic [4:0]  m_exp = '0, m_blk = 5'd15;

  always #2.5 clk_i = ~clk_i;

  norm_shifter u0 (.*);

  function automatic logic [4:0] f_exp(logic [15:0] d);
    int n = 0;
    for (int i = 14; i >= 0; i--) begin
      if (d[i] != d[15]) break;
      n++;
    end
    return 5'(n);
  endfunction

  function automatic logic [31:0] f_shift(logic [15:0] d, bit hi, bit ar, int amt);
    logic [31:0] p;
    p = hi ? {d, 16'h0} : {{16{ar & d[15]}}, d};
    if (amt >= 0) repeat (amt) p = p << 1;
    else repeat (-amt) p = {ar & p[31], p[31:1]};
    return p;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic drive(logic [2:0] op, logic [15:0] d, int cnt, bit hi, bit orm, bit blk, string tag);
    item_t it;
    int amt;
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; data_i = d; count_i = 8'(cnt);
    hi_sel_i = hi; or_mode_i = orm; blk_i = blk;
    if (op > 3'd4) return;
    if (op == 3'd4) begin
      m_exp = f_exp(d);
      if (blk && m_exp < m_blk) m_blk = m_exp;
    end else begin
      amt = (op == 3'd2) ? int'(f_exp(d)) : (op == 3'd3) ? -cnt : cnt;
      m_res = orm ? (m_res | f_shift(d, hi, op == 3'd1 || op == 3'd3, amt))
                  : f_shift(d, hi, op == 3'd1 || op == 3'd3, amt);
      if (op == 3'd2) m_exp = f_exp(d);
    end
    it.res = m_res; it.e = m_exp; it.blk = m_blk; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk_i);
      valid_i = 1'b0; op_i = 3'd0;
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R12: actual valid_o 1 expected 0 (no pending item)");
      end else begin
        item_t it;
        it = sb.pop_front();
        check({it.tag, " result"}, 64'(result_o), 64'(it.res));
        check({it.tag, " exp"}, 64'(exp_o), 64'(it.e));
        check({it.tag, " blk"}, 64'(blk_exp_o), 64'(it.blk));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset result", 64'(result_o), 64'h0);
    check("R1 reset blk", 64'(blk_exp_o), 64'd15);
    rst_ni = 1'b1;
    idle(2);
    check("R1 after release valid", 64'(valid_o), 64'h0);
    check("R1 after release exp", 64'(exp_o), 64'h0);

    drive(3'd0, 16'h1234, 4,    1, 0, 0, "R4 lsh left hi");
    drive(3'd0, 16'h8001, -1,   0, 0, 0, "R4 R3 lsh right lo");
    drive(3'd0, 16'hF00F, -20,  1, 0, 0, "R4 lsh right hi");
    drive(3'd1, 16'h8000, -4,   1, 0, 0, "R5 ash right hi");
    drive(3'd1, 16'h8000, 3,    0, 0, 0, "R3 ash lo sign ext");
    drive(3'd1, 16'hF000, -40,  0, 0, 0, "R6 ash -40");
    drive(3'd0, 16'hFFFF, 32,   1, 0, 0, "R6 lsh 32");
    drive(3'd1, 16'h8421, -128, 1, 0, 0, "R6 ash -128");
    drive(3'd0, 16'h8421, -32,  1, 0, 0, "R6 lsh -32");
    drive(3'd0, 16'h8421, 31,   0, 0, 0, "R6 lsh 31 edge");
    idle(1);
    drive(3'd4, 16'h0001, 0, 0, 0, 1, "R2 R10 exp 0001 blk");
    drive(3'd4, 16'hC000, 0, 0, 0, 1, "R2 R10 exp C000 blk");
    drive(3'd4, 16'hFFFF, 0, 0, 0, 1, "R2 R10 exp FFFF blk");
    drive(3'd4, 16'h0000, 0, 0, 0, 0, "R2 exp 0000 noblk");
    drive(3'd4, 16'h4000, 0, 0, 0, 0, "R10 exp 4000 noblk");
    drive(3'd4, 16'h2000, 0, 0, 0, 1, "R10 exp 2000 blk");
    drive(3'd2, 16'h0123, 5, 1, 0, 0, "R7 norm 0123 hi");
    drive(3'd2, 16'hFF80, 0, 1, 0, 0, "R7 norm FF80 hi");
    drive(3'd2, 16'h0001, 0, 0, 0, 0, "R7 R3 norm lo");
    drive(3'd2, 16'h0000, 0, 1, 0, 0, "R7 norm zero");
    drive(3'd3, 16'h4000, 3,  1, 0, 0, "R8 denorm 3");
    drive(3'd3, 16'h8000, 40, 1, 0, 0, "R8 R6 denorm 40");
    drive(3'd3, 16'h1234, -2, 0, 0, 0, "R8 denorm -2");
    drive(3'd0, 16'hABCD, -8, 1, 0, 0, "R9 dword upper pass");
    drive(3'd0, 16'h1234, -8, 0, 1, 0, "R9 dword lower pass or");
    drive(3'd2, 16'h00F0, 0,  0, 1, 0, "R9 norm or");
    idle(3);
    drive(3'd6, 16'hFFFF, 4, 1, 0, 1, "R11 op6");
    drive(3'd5, 16'h0001, 1, 0, 0, 1, "R11 op5");
    drive(3'd7, 16'h0000, 1, 0, 1, 1, "R11 op7");
    idle(3);
    check("R11 result held", 64'(result_o), 64'(m_res));
    check("R11 exp held", 64'(exp_o), 64'(m_exp));
    check("R11 blk held", 64'(blk_exp_o), 64'(m_blk));
    check("R12 valid low idle", 64'(valid_o), 64'h0);
    check("R12 all results seen", 64'(sb.size()), 64'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule